// File: doc/BRIEF.md
# Nibble register file with pair operations

This block holds the working storage of a small 4-bit processor: sixteen 4-bit index registers, a 256-entry nibble data memory, and the 8-bit pointer that selects one memory entry. Every clock the processor presents one operation code together with a register index, an 8-bit immediate byte and the current accumulator value. The block then either hands a nibble back for the accumulator, or updates its registers, pointer or memory.

Pairs of registers act as 8-bit values. An even register holds the high nibble and the odd register above it holds the low nibble. A pair can be loaded from the immediate byte or from a byte fetched out of an external data ROM. The ROM address always comes from registers 0 and 1, whatever pair the operation names. If the ROM reports that the addressed location holds no data, the fetch is refused and the block raises a one-cycle fault. The arithmetic unit and the accumulator register itself sit outside this block.

Top module: `nibble_regfile`

## Requirements
- R1: After reset all sixteen registers, every memory nibble and the data pointer read as zero, and `fault` and `accLoad` are low.
- R2: Operation codes are 0 idle, 1 load, 2 exchange, 3 increment, 4 pair-immediate, 5 pair-fetch, 6 pointer-set, 7 memory-read and 8 memory-write. Codes 9 to 15 behave as idle and change no state. `accLoad` is high in the same cycle for codes 1, 2 and 7 only, and `accOut` is zero whenever `accLoad` is low.
- R3: Load places the indexed register on `accOut` in the same cycle and changes no state.
- R4: Exchange places the old value of the indexed register on `accOut` and writes `accIn` into that register at the clock edge. A read and a write of one register in one cycle therefore return the old value.
- R5: Increment adds one to the indexed register modulo 16.
- R6: Pair-immediate clears bit 0 of the index. The even register takes `immByte[7:4]` and the odd register takes `immByte[3:0]`.
- R7: `romAddr` always equals register 0 times 16 plus register 1. A pair-fetch with `romValid` high writes `romData[7:4]` into the even register and `romData[3:0]` into the odd register of the named pair, with bit 0 of the index cleared.
- R8: A pair-fetch with `romValid` low leaves every register unchanged and drives `fault` high for exactly the following cycle.
- R9: Pointer-set loads `dataPtr` with the even register of the named pair as the high nibble and the odd register as the low nibble. No other operation changes `dataPtr`.
- R10: Memory-read places the nibble at `dataPtr` on `accOut` in the same cycle.
- R11: Memory-write stores `accIn` into the nibble at `dataPtr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opCode | input | 4 | Operation for this cycle |
| regIdx | input | 4 | Register index, or pair index with bit 0 ignored |
| immByte | input | 8 | Immediate byte for pair-immediate |
| accIn | input | 4 | Current accumulator value |
| accOut | output | 4 | Nibble to load into the accumulator |
| accLoad | output | 1 | `accOut` should be captured this cycle |
| romAddr | output | 8 | Data ROM address, from registers 0 and 1 |
| romData | input | 8 | Byte read from the data ROM |
| romValid | input | 1 | The ROM location holds data |
| dataPtr | output | 8 | Current data memory pointer |
| fault | output | 1 | One-cycle pulse after a refused ROM fetch |

## Verification
The bench targets pair operations named with an odd index. A design that ignored bit 0 there would write one register too high and would swap the nibble order. It fetches through pairs other than pair 0, where a design taking the ROM address from the named pair would read the wrong byte. It also fetches into pair 0 itself, which changes the address used by the next fetch. Refused fetches are checked for a pulse of exactly one cycle with the registers untouched; a partial write would leave a corrupted pair. Exchange and load are checked for the old register value in the same cycle, and increment is checked for wrap at 15. Unused codes are checked for no effect on registers, memory or pointer.

// File: rtl/nrf_pkg.sv
package nrf_pkg;

  typedef enum logic [3:0] {
    OP_IDLE     = 4'd0,
    OP_LOAD     = 4'd1,
    OP_SWAP     = 4'd2,
    OP_BUMP     = 4'd3,
    OP_PAIR_IMM = 4'd4,
    OP_PAIR_ROM = 4'd5,
    OP_PTR_SET  = 4'd6,
    OP_MEM_RD   = 4'd7,
    OP_MEM_WR   = 4'd8
  } opCode_e;

  // One strobe per action, raised by the control for the datapath.
  typedef struct packed {
    logic loadAcc;
    logic swap;
    logic bump;
    logic pairImm;
    logic pairRom;
    logic ptrSet;
    logic memRd;
    logic memWr;
  } strobe_t;

endpackage

// File: rtl/nrf_ctrl.sv
module nrf_ctrl
  import nrf_pkg::*;
#(
  parameter int REG_CNT = 16,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic [3:0]       opCode,
  input  logic [IDX_W-1:0] regIdx,
  output strobe_t          stb,
  output logic [IDX_W-1:0] regSel,
  output logic [IDX_W-1:0] pairHi,
  output logic [IDX_W-1:0] pairLo,
  output logic             accLoad
);

  always_comb begin
    stb = '0;
    case (opCode_e'(opCode))
      OP_LOAD:     stb.loadAcc = 1'b1;
      OP_SWAP:     stb.swap    = 1'b1;
      OP_BUMP:     stb.bump    = 1'b1;
      OP_PAIR_IMM: stb.pairImm = 1'b1;
      OP_PAIR_ROM: stb.pairRom = 1'b1;
      OP_PTR_SET:  stb.ptrSet  = 1'b1;
      OP_MEM_RD:   stb.memRd   = 1'b1;
      OP_MEM_WR:   stb.memWr   = 1'b1;
      default:     stb = '0;
    endcase
  end

  // Pair operations drop the index LSB: even register high, odd register low.
  assign regSel  = regIdx;
  assign pairHi  = {regIdx[IDX_W-1:1], 1'b0};
  assign pairLo  = {regIdx[IDX_W-1:1], 1'b1};
  assign accLoad = stb.loadAcc | stb.swap | stb.memRd;

endmodule

// File: rtl/nrf_datapath.sv
module nrf_datapath
  import nrf_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int REG_CNT   = 16,
  localparam int IDX_W    = $clog2(REG_CNT),
  localparam int ADDR_W   = 2 * NIB_W,
  localparam int MEM_DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  regSel,
  input  logic [IDX_W-1:0]  pairHi,
  input  logic [IDX_W-1:0]  pairLo,
  input  logic [ADDR_W-1:0] immByte,
  input  logic [NIB_W-1:0]  accIn,
  output logic [NIB_W-1:0]  accOut,
  output logic [ADDR_W-1:0] romAddr,
  input  logic [ADDR_W-1:0] romData,
  input  logic              romValid,
  output logic [ADDR_W-1:0] dataPtr,
  output logic              fault
);

  logic [REG_CNT-1:0][NIB_W-1:0] regBank;
  logic [NIB_W-1:0]              memBank [MEM_DEPTH];
  logic [ADDR_W-1:0]             pairByte;
  logic                          pairWr;

  // The indirect fetch address is tied to registers 0 and 1.
  assign romAddr  = {regBank[0], regBank[1]};
  assign pairByte = stb.pairImm ? immByte : romData;
  assign pairWr   = stb.pairImm | (stb.pairRom & romValid);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regBank <= '0;
    end else begin
      if (stb.swap) regBank[regSel] <= accIn;
      if (stb.bump) regBank[regSel] <= regBank[regSel] + NIB_W'(1);
      if (pairWr) begin
        regBank[pairHi] <= pairByte[ADDR_W-1:NIB_W];
        regBank[pairLo] <= pairByte[NIB_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataPtr <= '0;
      fault   <= 1'b0;
    end else begin
      if (stb.ptrSet) dataPtr <= {regBank[pairHi], regBank[pairLo]};
      fault <= stb.pairRom & ~romValid;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) memBank[i] <= '0;
    end else if (stb.memWr) begin
      memBank[dataPtr] <= accIn;
    end
  end

  // Reads see the state before this edge's write.
  always_comb begin
    accOut = '0;
    if (stb.memRd)                  accOut = memBank[dataPtr];
    else if (stb.loadAcc | stb.swap) accOut = regBank[regSel];
  end

  p_fault_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pairRom && !romValid) |=> fault);

  p_pair_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pairRom && !romValid) |=> $stable(regBank));

  p_swap_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.swap |=> regBank[$past(regSel)] == $past(accIn));

  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ptrSet |=> $stable(dataPtr));

endmodule

// File: rtl/nibble_regfile.sv
module nibble_regfile
  import nrf_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int REG_CNT = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [3:0]                   opCode,
  input  logic [$clog2(REG_CNT)-1:0]   regIdx,
  input  logic [2*NIB_W-1:0]           immByte,
  input  logic [NIB_W-1:0]             accIn,
  output logic [NIB_W-1:0]             accOut,
  output logic                         accLoad,
  output logic [2*NIB_W-1:0]           romAddr,
  input  logic [2*NIB_W-1:0]           romData,
  input  logic                         romValid,
  output logic [2*NIB_W-1:0]           dataPtr,
  output logic                         fault
);

  localparam int IDX_W = $clog2(REG_CNT);

  strobe_t          stb;
  logic [IDX_W-1:0] regSel;
  logic [IDX_W-1:0] pairHi;
  logic [IDX_W-1:0] pairLo;

  nrf_ctrl #(.REG_CNT(REG_CNT)) u_ctrl (
    .opCode  (opCode),
    .regIdx  (regIdx),
    .stb     (stb),
    .regSel  (regSel),
    .pairHi  (pairHi),
    .pairLo  (pairLo),
    .accLoad (accLoad)
  );

  nrf_datapath #(.NIB_W(NIB_W), .REG_CNT(REG_CNT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regSel   (regSel),
    .pairHi   (pairHi),
    .pairLo   (pairLo),
    .immByte  (immByte),
    .accIn    (accIn),
    .accOut   (accOut),
    .romAddr  (romAddr),
    .romData  (romData),
    .romValid (romValid),
    .dataPtr  (dataPtr),
    .fault    (fault)
  );

  p_fault_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> $past(opCode == 4'd5 && !romValid));

  p_rom_addr_pair0_r7: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd4 && regIdx[IDX_W-1:1] == '0) |=> romAddr == $past(immByte));

endmodule

// File: tb/nibble_regfile_bench.sv
module nibble_regfile_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] opCode = 4'd0;
  logic [3:0] regIdx = 4'd0;
  logic [7:0] immByte = 8'd0;
  logic [3:0] accIn = 4'd0;
  logic [3:0] accOut;
  logic       accLoad;
  logic [7:0] romAddr;
  logic [7:0] romData;
  logic       romValid;
  logic [7:0] dataPtr;
  logic       fault;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  int regsM [16];
  int memM  [256];
  int ptrM  = 0;
  bit faultM = 0;

  always #4 clk = ~clk;

  function automatic int romByteF(int a);
    return (a * 37 + 11) & 255;
  endfunction
  function automatic bit romOkF(int a);
    return a < 192;
  endfunction

  assign romData  = 8'(romByteF(int'(romAddr)));
  assign romValid = romOkF(int'(romAddr));

  nibble_regfile u_nibble_regfile (
    .clk(clk), .rstN(rstN), .opCode(opCode), .regIdx(regIdx),
    .immByte(immByte), .accIn(accIn), .accOut(accOut), .accLoad(accLoad),
    .romAddr(romAddr), .romData(romData), .romValid(romValid),
    .dataPtr(dataPtr), .fault(fault)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string opTag(int op);
    case (op)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R9";
      7: return "R10";
      8: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic finish();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // One operation: check registered outputs, drive, check same-cycle outputs,
  // then advance the reference model at the edge.
  task automatic step(int op, int idx, int imm, int acc, string tagIn = "");
    string tag;
    int expOut, r0r1, even;
    bit expLoad;
    tag = (tagIn == "") ? opTag(op) : tagIn;
    @(negedge clk);
    check(faultM ? "R8" : tag, "fault", int'(fault), int'(faultM));
    check((tagIn == "") ? "R9" : tag, "dataPtr", int'(dataPtr), ptrM);
    opCode = 4'(op); regIdx = 4'(idx); immByte = 8'(imm); accIn = 4'(acc);
    #1;
    r0r1 = regsM[0] * 16 + regsM[1];
    even = idx & 14;
    expLoad = (op == 1 || op == 2 || op == 7);
    expOut = 0;
    if (op == 1 || op == 2) expOut = regsM[idx];
    if (op == 7) expOut = memM[ptrM];
    check(tag, "accLoad", int'(accLoad), int'(expLoad));
    check(tag, "accOut", int'(accOut), expOut);
    check((tagIn == "") ? "R7" : tag, "romAddr", int'(romAddr), r0r1);
    @(posedge clk);
    faultM = 0;
    case (op)
      2: regsM[idx] = acc;
      3: regsM[idx] = (regsM[idx] + 1) % 16;
      4: begin regsM[even] = (imm >> 4) & 15; regsM[even + 1] = imm & 15; end
      5: if (romOkF(r0r1)) begin
           regsM[even] = romByteF(r0r1) >> 4; regsM[even + 1] = romByteF(r0r1) & 15;
         end else faultM = 1;
      6: ptrM = regsM[even] * 16 + regsM[even + 1];
      8: memM[ptrM] = acc;
      default: ;
    endcase
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish();
  end

  initial begin
    foreach (regsM[i]) regsM[i] = 0;
    foreach (memM[i])  memM[i]  = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    for (int i = 0; i < 16; i++) step(1, i, 0, 0, "R1");
    step(7, 0, 0, 0, "R1");
    // R6: odd index names the pair below it, high nibble into even register
    step(4, 3, 8'hA7, 0);
    step(1, 2, 0, 0, "R6");
    step(1, 3, 0, 0, "R6");
    step(4, 14, 8'h5C, 0);
    // R5: wrap at 15
    step(4, 9, 8'h0F, 0);
    step(3, 9, 0, 0);
    step(1, 9, 0, 0, "R5");
    // R4: exchange returns old value, new value visible next cycle
    step(2, 2, 0, 4'h6);
    step(2, 2, 0, 4'h1);
    step(1, 2, 0, 0, "R4");
    // R7: fetch through pair 0 address into pair 6, then into pair 0 itself
    step(4, 0, 8'h2B, 0);
    step(5, 13, 0, 0);
    step(1, 12, 0, 0, "R7");
    step(1, 13, 0, 0, "R7");
    step(5, 1, 0, 0);
    step(5, 4, 0, 0);
    // R8: refused fetches, back to back, then a good one
    step(4, 0, 8'hC5, 0);
    step(5, 6, 0, 0);
    step(5, 6, 0, 0);
    step(0, 0, 0, 0, "R8");
    step(1, 6, 0, 0, "R8");
    step(1, 7, 0, 0, "R8");
    // R9-R11: pointer, write, read
    step(4, 10, 8'h3E, 0);
    step(6, 11, 0, 0);
    step(8, 0, 0, 4'h9);
    step(7, 0, 0, 0);
    step(6, 2, 0, 0);
    step(8, 0, 0, 4'h4);
    step(6, 10, 0, 0);
    step(7, 0, 0, 0, "R11");
    // R2: unused codes leave state alone
    for (int c = 9; c < 16; c++) step(c, c, 8'hFF, 4'hF);
    step(7, 0, 0, 0, "R2");
    for (int i = 0; i < 16; i++) step(1, i, 0, 0, "R2");
    // mixed traffic against the model
    for (int n = 0; n < 1500; n++)
      step($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 15));
    for (int i = 0; i < 16; i++) step(1, i, 0, 0);
    step(0, 0, 0, 0);
    finish();
  end

endmodule